// File: doc/BRIEF.md
# Edge-Capturing Interrupt Latch Bank

This block watches a set of already-synchronised input levels (24 by default) and turns a chosen edge on any line into a held interrupt request. Each line selects its active edge on its own: rising or falling. A captured request stays set until software writes a one to that line's bit in an acknowledge register. A new edge that arrives in the same cycle as its own acknowledge is kept, so no event is lost while an earlier one is being serviced.

Software reaches the block through a simple synchronous register port that has a 16-bit data path and two byte-lane enables. A register wider than the data path spans several consecutive word addresses. Each line has one bit in each of five per-line registers: edge select, mask, raw request, masked pending and acknowledge. A single interrupt output is the OR of all pending bits. Reads are combinational from the address. Writes take effect at the rising clock edge.

Top module: `edge_irq_bank`

## Requirements
- R1: After reset, the edge-select, mask and request registers are all zero and `irq` is low. The internal previous sample resets to 0, so with the reset polarity a line that is held high across reset raises no event.
- R2: An edge-select bit of 1 captures a rising edge (sample 0 then 1 on consecutive clocks). A bit of 0 captures a falling edge (1 then 0). The request bit is set by the clock edge that first samples the new level, and the opposite edge is ignored.
- R3: A request is latched whatever the mask bit is. It stays set until it is acknowledged. A line that stays at its active level raises no further event after acknowledge.
- R4: The pending register reads as request AND mask. `irq` is high exactly when at least one pending bit is 1, with no added cycle of delay in the default configuration.
- R5: Writing 1 to bit n of the acknowledge register clears request bit n only. Bits written as 0 leave their requests unchanged.
- R6: If an active edge on line n and an acknowledge of bit n fall in the same cycle, request bit n stays set.
- R7: Changing an edge-select bit while the line is steady raises no event.
- R8: The address is {register index[2:0], word[0]}. The indices are: 0 edge select (read/write), 1 mask (read/write), 2 request (read only), 3 pending (read only), 4 acknowledge (write only). Word 0 carries lines 15..0 in data bits 15..0. Word 1 carries lines 23..16 in data bits 7..0. Bits with no line behind them read 0.
- R9: `bus_be[0]` enables data bits 7..0 and `bus_be[1]` enables data bits 15..8 of a write. Register bits in a disabled lane keep their value.
- R10: Writes to indices 2, 3, 5, 6 and 7 change no state. The acknowledge register and indices 5 to 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lines_in | input | 24 | Synchronised line levels |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_addr | input | 4 | {register index, word select} |
| bus_be | input | 2 | Byte-lane enables for writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq | output | 1 | OR of all pending bits |

## Verification
The bench pairs an acknowledge with a fresh active edge on the same line in one cycle. A design that lets the clear win would drop that event and read the request back as 0. It flips an edge-select bit under a steady high line: a detector that compares against the polarity instead of the previous sample would latch a spurious request. It writes single byte lanes and writes to the read-only and unmapped indices. A faulty decode would corrupt neighbouring lane bits or let software set requests directly. The random phase mixes slow line toggles with writes to every index. A bench model compares the interrupt output every cycle, which exposes an acknowledge that spills onto other lines or a pending term that ignores the mask.

// File: rtl/eib_pkg.sv
package eib_pkg;
   localparam int REG_IDX_W = 3;

   typedef enum logic [REG_IDX_W-1:0] {
      REG_EDGE_SEL = 3'd0,
      REG_MASK     = 3'd1,
      REG_REQUEST  = 3'd2,
      REG_PENDING  = 3'd3,
      REG_ACK      = 3'd4
   } eib_reg_e;

   function automatic int words_for(input int lines, input int bus_w);
      return (lines + bus_w - 1) / bus_w;
   endfunction

   function automatic int sel_width(input int words);
      return (words > 1) ? $clog2(words) : 1;
   endfunction
endpackage

// File: rtl/eib_edge_detect.sv
module eib_edge_detect #(
   parameter int NUM_LINES = 24
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] lines_in,
   input  logic [NUM_LINES-1:0] edge_sel,
   output logic [NUM_LINES-1:0] edge_vec
);
   logic [NUM_LINES-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lines_in;
   end

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      logic rise, fall;
      assign rise = lines_in[i] & ~prev_q[i];
      assign fall = ~lines_in[i] & prev_q[i];
      assign edge_vec[i] = edge_sel[i] ? rise : fall;
   end

   // R7: an event only where the sample really changed
   a_r7_edge_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_vec & ~(lines_in ^ prev_q)) == '0);
endmodule

// File: rtl/eib_req_latch.sv
module eib_req_latch #(
   parameter int NUM_LINES = 24
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] edge_vec,
   input  logic [NUM_LINES-1:0] ack_mask,
   output logic [NUM_LINES-1:0] req_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= '0;
      else        req_q <= (req_q & ~ack_mask) | edge_vec;
   end

   // R3: a set request survives unless acknowledged
   a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (($past(req_q) & ~$past(ack_mask)) & ~req_q) == '0);

   // R5: acknowledged bits with no new edge are cleared
   a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ((ack_mask & ~edge_vec) != '0) |=> (req_q & $past(ack_mask & ~edge_vec)) == '0);

   // R6: a fresh edge wins over a same-cycle acknowledge
   a_r6_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_vec != '0) |=> (req_q & $past(edge_vec)) == $past(edge_vec));
endmodule

// File: rtl/eib_bus_regs.sv
module eib_bus_regs
   import eib_pkg::*;
#(
   parameter int NUM_LINES = 24,
   parameter int BUS_W     = 16,
   localparam int WORDS    = words_for(NUM_LINES, BUS_W),
   localparam int WSEL_W   = sel_width(WORDS),
   localparam int ADDR_W   = REG_IDX_W + WSEL_W,
   localparam int LANES    = BUS_W / 8,
   localparam int PAD_W    = WORDS * BUS_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_we,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [LANES-1:0]     bus_be,
   input  logic [BUS_W-1:0]     bus_wdata,
   input  logic [NUM_LINES-1:0] req_q,
   output logic [NUM_LINES-1:0] edge_sel_q,
   output logic [NUM_LINES-1:0] mask_q,
   output logic [NUM_LINES-1:0] ack_mask,
   output logic [BUS_W-1:0]     bus_rdata
);
   logic [REG_IDX_W-1:0] reg_idx;
   logic [WSEL_W-1:0]    word_sel;
   logic [NUM_LINES-1:0] wmask, wdata_rep;
   logic                 hit_edge, hit_mask, hit_ack;

   assign reg_idx  = bus_addr[ADDR_W-1 -: REG_IDX_W];
   assign word_sel = bus_addr[WSEL_W-1:0];

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_wbit
      localparam int WI = i / BUS_W;
      localparam int BI = (i % BUS_W) / 8;
      assign wmask[i]     = bus_we && (word_sel == WSEL_W'(WI)) && bus_be[BI];
      assign wdata_rep[i] = bus_wdata[i % BUS_W];
   end

   assign hit_edge = (reg_idx == REG_EDGE_SEL);
   assign hit_mask = (reg_idx == REG_MASK);
   assign hit_ack  = (reg_idx == REG_ACK);

   assign ack_mask = hit_ack ? (wdata_rep & wmask) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         edge_sel_q <= '0;
         mask_q     <= '0;
      end else begin
         if (hit_edge) edge_sel_q <= (edge_sel_q & ~wmask) | (wdata_rep & wmask);
         if (hit_mask) mask_q     <= (mask_q & ~wmask) | (wdata_rep & wmask);
      end
   end

   logic [NUM_LINES-1:0] sel_vec;
   logic [PAD_W-1:0]     sel_pad;

   always_comb begin
      sel_vec = '0;
      if (reg_idx == REG_EDGE_SEL)     sel_vec = edge_sel_q;
      else if (reg_idx == REG_MASK)    sel_vec = mask_q;
      else if (reg_idx == REG_REQUEST) sel_vec = req_q;
      else if (reg_idx == REG_PENDING) sel_vec = req_q & mask_q;
      sel_pad   = PAD_W'(sel_vec);
      bus_rdata = '0;
      for (int w = 0; w < WORDS; w++) begin
         if (word_sel == WSEL_W'(w)) bus_rdata = sel_pad[w*BUS_W +: BUS_W];
      end
   end

   // R9: bits outside the enabled lanes keep their value
   a_r9_lane_untouched: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && hit_edge) |=> ((edge_sel_q ^ $past(edge_sel_q)) & ~$past(wmask)) == '0);

   // R10: writes to read-only or unmapped indices leave control state alone
   a_r10_ro_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && !hit_edge && !hit_mask) |=> ($stable(edge_sel_q) && $stable(mask_q)));
endmodule

// File: rtl/edge_irq_bank.sv
module edge_irq_bank
   import eib_pkg::*;
#(
   parameter int NUM_LINES = 24,
   parameter int BUS_W     = 16,
   parameter bit IRQ_REG   = 1'b0,
   localparam int WORDS    = words_for(NUM_LINES, BUS_W),
   localparam int WSEL_W   = sel_width(WORDS),
   localparam int ADDR_W   = REG_IDX_W + WSEL_W,
   localparam int LANES    = BUS_W / 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] lines_in,
   input  logic                 bus_we,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [LANES-1:0]     bus_be,
   input  logic [BUS_W-1:0]     bus_wdata,
   output logic [BUS_W-1:0]     bus_rdata,
   output logic                 irq
);
   if (BUS_W < 8 || (BUS_W % 8) != 0) begin : g_bad_bus
      $error("edge_irq_bank: BUS_W must be a positive multiple of 8");
   end
   if (NUM_LINES < 1) begin : g_bad_lines
      $error("edge_irq_bank: NUM_LINES must be at least 1");
   end

   logic [NUM_LINES-1:0] edge_vec, ack_mask, req_q, edge_sel_q, mask_q, pending;

   eib_edge_detect #(.NUM_LINES(NUM_LINES)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .lines_in (lines_in),
      .edge_sel (edge_sel_q),
      .edge_vec (edge_vec)
   );

   eib_req_latch #(.NUM_LINES(NUM_LINES)) u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .edge_vec (edge_vec),
      .ack_mask (ack_mask),
      .req_q    (req_q)
   );

   eib_bus_regs #(.NUM_LINES(NUM_LINES), .BUS_W(BUS_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_we     (bus_we),
      .bus_addr   (bus_addr),
      .bus_be     (bus_be),
      .bus_wdata  (bus_wdata),
      .req_q      (req_q),
      .edge_sel_q (edge_sel_q),
      .mask_q     (mask_q),
      .ack_mask   (ack_mask),
      .bus_rdata  (bus_rdata)
   );

   assign pending = req_q & mask_q;

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= |pending;
      end
      assign irq = irq_q;
      // R4: a registered interrupt follows a request of the cycle before
      a_r4_irq_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
         rst_n |=> (!irq || $past(req_q) != '0));
   end else begin : g_irq_comb
      assign irq = |pending;
      // R4: no interrupt without a latched request
      a_r4_irq_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
         irq |-> (req_q != '0));
   end
endmodule

// File: tb/edge_irq_bank_tb.sv
`timescale 1ns/1ps
module edge_irq_bank_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] lines_in = 24'hFFFFFF;
   logic        bus_we = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [1:0]  bus_be = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [23:0] m_pol = '0, m_en = '0, m_req = '0, m_prev = '0;

   always #4 clk = ~clk;

   edge_irq_bank u_dut (
      .clk(clk), .rst_n(rst_n), .lines_in(lines_in), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq(irq)
   );

   function automatic logic [23:0] lane_mask(input logic [3:0] a, input logic [1:0] be);
      logic [31:0] m = '0;
      for (int b = 0; b < 2; b++) if (be[b]) m[a[0]*16 + b*8 +: 8] = 8'hFF;
      return m[23:0];
   endfunction

   function automatic logic [15:0] m_read(input logic [3:0] a);
      logic [23:0] v;
      logic [31:0] p;
      case (a[3:1])
         3'd0: v = m_pol;
         3'd1: v = m_en;
         3'd2: v = m_req;
         3'd3: v = m_req & m_en;
         default: v = '0;
      endcase
      p = {8'h00, v};
      return a[0] ? p[31:16] : p[15:0];
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one clock with given lines and optional write; the model follows at the edge
   task automatic step(input logic [23:0] l, input logic we, input logic [3:0] a,
                       input logic [1:0] be, input logic [15:0] d, input string tag);
      logic [23:0] mk, dt, edg, clr;
      @(negedge clk);
      lines_in = l; bus_we = we; bus_addr = a; bus_be = be; bus_wdata = d;
      @(posedge clk);
      mk  = we ? lane_mask(a, be) : '0;
      dt  = {d[7:0], d};
      edg = (m_pol & l & ~m_prev) | (~m_pol & ~l & m_prev);
      clr = (a[3:1] == 3'd4) ? (dt & mk) : '0;
      m_req = (m_req & ~clr) | edg;
      if (a[3:1] == 3'd0) m_pol = (m_pol & ~mk) | (dt & mk);
      if (a[3:1] == 3'd1) m_en  = (m_en & ~mk) | (dt & mk);
      m_prev = l;
      #1;
      chk(irq == |(m_req & m_en), {tag, " R4 irq"}, 32'(irq), 32'(|(m_req & m_en)));
   endtask

   task automatic wr(input logic [3:0] a, input logic [1:0] be, input logic [15:0] d, input string tag);
      step(lines_in, 1'b1, a, be, d, tag);
   endtask

   // read against the model, and against a literal when use_lit is set
   task automatic rd(input logic [3:0] a, input bit use_lit, input logic [15:0] lit, input string tag);
      @(negedge clk);
      bus_we = 1'b0; bus_addr = a;
      #1;
      chk(bus_rdata == m_read(a), {tag, " model"}, 32'(bus_rdata), 32'(m_read(a)));
      if (use_lit) chk(bus_rdata == lit, {tag, " literal"}, 32'(bus_rdata), 32'(lit));
      step(lines_in, 1'b0, a, 2'b00, 16'h0, tag);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      logic [23:0] cur;
      void'($urandom(32'h00C0FFEE));
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state and R8/R10 zero reads of every address
      chk(irq == 1'b0, "R1 irq after reset", 32'(irq), 0);
      for (int a = 0; a < 16; a++) rd(4'(a), 1'b1, 16'h0000, "R1 reset read");

      // R8 map and R9 lanes
      wr(4'b0000, 2'b11, 16'h00FF, "R8 pol w0");
      wr(4'b0001, 2'b01, 16'h000F, "R8 pol w1");
      rd(4'b0000, 1'b1, 16'h00FF, "R8 pol w0 read");
      rd(4'b0001, 1'b1, 16'h000F, "R8 pol w1 read");
      wr(4'b0000, 2'b10, 16'hAB12, "R9 upper lane");
      rd(4'b0000, 1'b1, 16'hABFF, "R9 lower lane kept");
      wr(4'b0001, 2'b10, 16'hFF00, "R8 unused byte");
      rd(4'b0001, 1'b1, 16'h000F, "R8 unused bits read 0");

      // R2 rising select on line 0
      step(24'hFFFFFE, 1'b0, 4'b0000, 2'b00, 16'h0, "R2 fall ignored");
      rd(4'b0100, 1'b1, 16'h0000, "R2 opposite edge ignored");
      step(24'hFFFFFF, 1'b0, 4'b0000, 2'b00, 16'h0, "R2 rise");
      rd(4'b0100, 1'b1, 16'h0001, "R2 rising edge captured");
      chk(irq == 1'b0, "R3 latched while masked", 32'(irq), 0);
      rd(4'b0110, 1'b1, 16'h0000, "R4 pending masked");
      wr(4'b0010, 2'b01, 16'h0001, "R4 unmask");
      rd(4'b0110, 1'b1, 16'h0001, "R4 pending");
      chk(irq == 1'b1, "R4 irq high", 32'(irq), 1);

      // R2 falling select on line 20
      step(24'hEFFFFF, 1'b0, 4'b0000, 2'b00, 16'h0, "R2 fall");
      rd(4'b0101, 1'b1, 16'h0010, "R2 falling edge captured");

      // R10 read-only and unmapped writes
      wr(4'b0100, 2'b11, 16'h0000, "R10 req write");
      wr(4'b0110, 2'b11, 16'h0000, "R10 pend write");
      wr(4'b1010, 2'b11, 16'hFFFF, "R10 unmapped write");
      rd(4'b0100, 1'b1, 16'h0001, "R10 req unchanged");
      rd(4'b0101, 1'b1, 16'h0010, "R10 req hi unchanged");
      rd(4'b1000, 1'b1, 16'h0000, "R10 ack reads 0");
      rd(4'b1010, 1'b1, 16'h0000, "R10 unmapped reads 0");
      rd(4'b0000, 1'b1, 16'hABFF, "R10 pol unchanged");

      // R5 single-line acknowledge
      wr(4'b1000, 2'b11, 16'h0001, "R5 ack bit0");
      rd(4'b0100, 1'b1, 16'h0000, "R5 bit0 cleared");
      rd(4'b0101, 1'b1, 16'h0010, "R5 bit20 kept");
      chk(irq == 1'b0, "R4 irq low after ack", 32'(irq), 0);
      // R3 steady active level does not re-raise
      step(lines_in, 1'b0, 4'b0000, 2'b00, 16'h0, "R3 steady");
      rd(4'b0100, 1'b1, 16'h0000, "R3 no re-raise");

      // R6 edge and acknowledge together
      step(24'hEFFFFE, 1'b0, 4'b0000, 2'b00, 16'h0, "R6 prep");
      step(24'hEFFFFF, 1'b1, 4'b1000, 2'b11, 16'h0001, "R6 same cycle");
      rd(4'b0100, 1'b1, 16'h0001, "R6 edge wins");

      // R7 polarity flip on a steady high line 5
      wr(4'b0000, 2'b01, 16'h00DF, "R7 flip");
      rd(4'b0100, 1'b1, 16'h0001, "R7 no event on flip");
      wr(4'b0000, 2'b01, 16'h00FF, "R7 flip back");
      rd(4'b0100, 1'b1, 16'h0001, "R7 no event on flip back");

      wr(4'b1000, 2'b11, 16'hFFFF, "R5 ack all w0");
      wr(4'b1001, 2'b01, 16'h00FF, "R5 ack all w1");
      rd(4'b0100, 1'b1, 16'h0000, "R5 all cleared w0");
      rd(4'b0101, 1'b1, 16'h0000, "R5 all cleared w1");

      // constrained random phase
      cur = lines_in;
      for (int n = 0; n < 3000; n++) begin
         int op;
         logic [3:0] a;
         op = int'($urandom_range(0, 9));
         cur = cur ^ (24'($urandom) & 24'($urandom) & 24'($urandom));
         a = {3'($urandom_range(0, 7)), 1'($urandom)};
         if (op < 4) step(cur, 1'b1, a, 2'($urandom), 16'($urandom), "R5 R9 random write");
         else if (op < 7) rd(a, 1'b0, 16'h0, "R8 random read");
         else step(cur, 1'b0, 4'b0000, 2'b00, 16'h0, "R2 random idle");
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule